// File: doc/BRIEF.md
# Overlapping Sub-Register File

This block holds the working registers of a small processor core. There are eight 32-bit general registers and six 16-bit segment registers. The eight general registers are four data registers (A, B, C, D), two pointer registers (stack and base) and two index registers (source and destination). Each register can be reached under several names of different widths, and all of those names share the same storage. A data register can be read or written as a double word, as its low word, or as either of its two low bytes. The pointer and index registers offer only the double-word and word views. The segment registers offer only the word view.

The block has two combinational read ports and one write port. Each port carries a register select and a size select. A separate swap command exchanges the contents of two registers on one clock edge. A narrow write merges into its register and leaves the other bits as they were. A segment write whose source is flagged as an immediate is refused, and an error output reports it. An encoding that addresses no view is refused the same way.

Top module: `subreg_file`

## Requirements
- R1: The select encoding is: 0 = A, 1 = B, 2 = C, 3 = D, 4 = stack pointer, 5 = base pointer, 6 = source index, 7 = destination index, 8 = code segment, 9 = data segment, 10 = stack segment, 11 = extra segment, 12 and 13 = the two further data segments. Selects 14 and 15 address nothing.
- R2: The size encoding is: 0 = low byte (bits 7:0), 1 = high byte (bits 15:8), 2 = word (bits 15:0), 3 = double word (bits 31:0). Narrow reads are zero-extended into bit 0 upward. With A = 1A2B3C4Dh, the reads return 4Dh, 3Ch, 3C4Dh and 1A2B3C4Dh.
- R3: The two read ports are combinational and independent. A read of a view the register lacks returns zero. This covers a byte view of registers 4 to 7, any view other than the word view of a segment register, and selects 14 and 15.
- R4: A byte or word write changes only the addressed bits and keeps all other bits of the register. A high-byte write takes its value from wr_data[7:0].
- R5: A write takes effect at the rising clock edge and is not visible before it. A synchronous reset clears every register to zero.
- R6: A write to a view the register lacks, or to select 14 or 15, is ignored, and wr_err is high in the same cycle.
- R7: A segment-register write with wr_imm = 1 is ignored, and wr_err is high in the same cycle. For registers 0 to 7, wr_imm has no effect.
- R8: A swap exchanges two registers in one edge. A segment register receives the low 16 bits of its partner, and a general register receives a segment value zero-extended. A swap that names select 14 or 15 changes nothing.
- R9: A swap whose two selects name the same register leaves that register unchanged.
- R10: When a swap and an accepted write fall in the same cycle, the write merges into the value its register holds after the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd0_sel | input | 4 | Read port 0 register select |
| rd0_size | input | 2 | Read port 0 view size |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd1_sel | input | 4 | Read port 1 register select |
| rd1_size | input | 2 | Read port 1 view size |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| wr_en | input | 1 | Write request |
| wr_sel | input | 4 | Write register select |
| wr_size | input | 2 | Write view size |
| wr_imm | input | 1 | Write source is an immediate |
| wr_data | input | 32 | Write data, low bits used for narrow views |
| wr_err | output | 1 | Current write request is refused |
| sw_en | input | 1 | Swap request |
| sw_a | input | 4 | First swap register select |
| sw_b | input | 4 | Second swap register select |

## Verification
A swap and a write can land in the same cycle, and the write may target one of the swapped registers. The bench triggers this by asserting sw_en on A and the base pointer together with a low-byte write to A. It then reads both registers to confirm two things. A must hold the base pointer's old upper 24 bits beneath the new byte. The base pointer must hold A's old value.

// File: rtl/subreg_pkg.sv
`timescale 1ns/1ps
package subreg_pkg;
    localparam int GP_CNT  = 4;
    localparam int PTR_CNT = 4;
    localparam int SEG_CNT = 6;
    localparam int REG_CNT = GP_CNT + PTR_CNT + SEG_CNT;
    localparam int SEL_W   = $clog2(REG_CNT);
    localparam int XLEN    = 32;
    localparam int SEG_W   = 16;
    localparam int BYTE_W  = 8;

    typedef enum logic [1:0] {
        SZ_LO    = 2'd0,
        SZ_HI    = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } view_e;

    typedef enum logic [1:0] {
        CL_GP, CL_PTR, CL_SEG, CL_NONE
    } cls_e;

    typedef logic [REG_CNT-1:0][XLEN-1:0] bank_t;

    typedef struct packed {
        bank_t bank;
    } rf_state_t;

    function automatic cls_e class_of(input logic [SEL_W-1:0] sel);
        if (int'(sel) < GP_CNT)                  return CL_GP;
        else if (int'(sel) < GP_CNT + PTR_CNT)   return CL_PTR;
        else if (int'(sel) < REG_CNT)            return CL_SEG;
        else                                     return CL_NONE;
    endfunction

    function automatic logic view_ok(input cls_e c, input view_e v);
        case (c)
            CL_GP:   return 1'b1;
            CL_PTR:  return (v == SZ_WORD) || (v == SZ_DWORD);
            CL_SEG:  return (v == SZ_WORD);
            default: return 1'b0;
        endcase
    endfunction

    // Shape a value to the storage of a register class.
    function automatic logic [XLEN-1:0] fit(input cls_e c, input logic [XLEN-1:0] v);
        if (c == CL_SEG) return {{(XLEN-SEG_W){1'b0}}, v[SEG_W-1:0]};
        else             return v;
    endfunction
endpackage

// File: rtl/subreg_rd_view.sv
`timescale 1ns/1ps
module subreg_rd_view
    import subreg_pkg::*;
(
    input  logic [XLEN-1:0]  reg_val,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       size,
    output logic [XLEN-1:0]  data
);
    cls_e  cls;
    view_e v;

    always_comb begin
        cls  = class_of(sel);
        v    = view_e'(size);
        data = '0;
        if (view_ok(cls, v)) begin
            case (v)
                SZ_LO:    data[BYTE_W-1:0] = reg_val[BYTE_W-1:0];
                SZ_HI:    data[BYTE_W-1:0] = reg_val[2*BYTE_W-1:BYTE_W];
                SZ_WORD:  data[SEG_W-1:0]  = reg_val[SEG_W-1:0];
                default:  data             = reg_val;
            endcase
        end
    end
endmodule

// File: rtl/subreg_wr_merge.sv
`timescale 1ns/1ps
module subreg_wr_merge
    import subreg_pkg::*;
(
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       size,
    input  logic             imm,
    input  logic [XLEN-1:0]  old_val,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  new_val,
    output logic             accept,
    output logic             reject
);
    cls_e            cls;
    view_e           v;
    logic [XLEN-1:0] merged;

    always_comb begin
        cls = class_of(sel);
        v   = view_e'(size);
        case (v)
            SZ_LO:   merged = {old_val[XLEN-1:BYTE_W], wdata[BYTE_W-1:0]};
            SZ_HI:   merged = {old_val[XLEN-1:2*BYTE_W], wdata[BYTE_W-1:0],
                               old_val[BYTE_W-1:0]};
            SZ_WORD: merged = {old_val[XLEN-1:SEG_W], wdata[SEG_W-1:0]};
            default: merged = wdata;
        endcase
        new_val = fit(cls, merged);
        accept  = en && view_ok(cls, v) && !((cls == CL_SEG) && imm);
        reject  = en && !accept;
    end
endmodule

// File: rtl/subreg_swap.sv
`timescale 1ns/1ps
module subreg_swap
    import subreg_pkg::*;
(
    input  bank_t            bank_in,
    input  logic             en,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    output bank_t            bank_out
);
    cls_e            cls_a;
    cls_e            cls_b;
    logic [XLEN-1:0] val_a;
    logic [XLEN-1:0] val_b;

    always_comb begin
        cls_a    = class_of(sel_a);
        cls_b    = class_of(sel_b);
        val_a    = '0;
        val_b    = '0;
        bank_out = bank_in;
        if (en && (cls_a != CL_NONE) && (cls_b != CL_NONE)) begin
            val_a           = bank_in[sel_a];
            val_b           = bank_in[sel_b];
            bank_out[sel_a] = fit(cls_a, val_b);
            bank_out[sel_b] = fit(cls_b, val_a);
        end
    end
endmodule

// File: rtl/subreg_file.sv
`timescale 1ns/1ps
module subreg_file
    import subreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] rd0_sel,
    input  logic [1:0]       rd0_size,
    output logic [XLEN-1:0]  rd0_data,
    input  logic [SEL_W-1:0] rd1_sel,
    input  logic [1:0]       rd1_size,
    output logic [XLEN-1:0]  rd1_data,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [1:0]       wr_size,
    input  logic             wr_imm,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_err,
    input  logic             sw_en,
    input  logic [SEL_W-1:0] sw_a,
    input  logic [SEL_W-1:0] sw_b
);
    localparam int RD_PORTS = 2;

    rf_state_t state_d;
    rf_state_t state_q;

    // Read ports
    logic [RD_PORTS-1:0][SEL_W-1:0] rsel;
    logic [RD_PORTS-1:0][1:0]       rsz;
    logic [RD_PORTS-1:0][XLEN-1:0]  rdat;

    assign rsel = {rd1_sel, rd0_sel};
    assign rsz  = {rd1_size, rd0_size};

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        logic [XLEN-1:0] rv;
        assign rv = (class_of(rsel[p]) != CL_NONE) ? state_q.bank[rsel[p]] : '0;
        subreg_rd_view u_view (
            .reg_val (rv),
            .sel     (rsel[p]),
            .size    (rsz[p]),
            .data    (rdat[p])
        );
    end

    assign rd0_data = rdat[0];
    assign rd1_data = rdat[1];

    // Swap stage, then the write merges on top of it
    bank_t           bank_sw;
    logic [XLEN-1:0] wr_old;
    logic [XLEN-1:0] wr_new;
    logic            wr_accept;
    logic            wr_reject;

    subreg_swap u_swap (
        .bank_in  (state_q.bank),
        .en       (sw_en),
        .sel_a    (sw_a),
        .sel_b    (sw_b),
        .bank_out (bank_sw)
    );

    assign wr_old = (class_of(wr_sel) != CL_NONE) ? bank_sw[wr_sel] : '0;

    subreg_wr_merge u_merge (
        .en      (wr_en),
        .sel     (wr_sel),
        .size    (wr_size),
        .imm     (wr_imm),
        .old_val (wr_old),
        .wdata   (wr_data),
        .new_val (wr_new),
        .accept  (wr_accept),
        .reject  (wr_reject)
    );

    assign wr_err = wr_reject;

    always_comb begin
        state_d.bank = bank_sw;
        if (wr_accept) begin
            state_d.bank[wr_sel] = wr_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/subreg_file_chk.sv
`timescale 1ns/1ps
module subreg_file_chk
    import subreg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_err,
    input logic [SEL_W-1:0] wr_sel,
    input logic [1:0]       wr_size,
    input logic             sw_en,
    input logic [SEL_W-1:0] sw_a,
    input logic [SEL_W-1:0] sw_b,
    input bank_t            bank_q
);
    localparam int GEN_CNT = GP_CNT + PTR_CNT;

    assert_reset_clear_R5: assert property (@(posedge clk)
        rst |=> (bank_q == '0));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !sw_en) |=> (bank_q == $past(bank_q)));

    assert_refused_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_err && !sw_en) |=> (bank_q == $past(bank_q)));

    assert_low_byte_merge_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_err && !sw_en && (wr_size == 2'd0))
        |=> (bank_q[$past(wr_sel)][XLEN-1:BYTE_W] == $past(bank_q[wr_sel][XLEN-1:BYTE_W])));

    assert_swap_general_R8: assert property (@(posedge clk) disable iff (rst)
        (sw_en && !wr_en && (int'(sw_a) < GEN_CNT) && (int'(sw_b) < GEN_CNT))
        |=> (bank_q[$past(sw_a)] == $past(bank_q[sw_b])));

    assert_swap_self_R9: assert property (@(posedge clk) disable iff (rst)
        (sw_en && !wr_en && (sw_a == sw_b)) |=> (bank_q == $past(bank_q)));

    for (genvar s = 0; s < SEG_CNT; s++) begin : g_seg
        assert_seg_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
            bank_q[GEN_CNT+s][XLEN-1:SEG_W] == '0);
    end
endmodule

bind subreg_file subreg_file_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_err  (wr_err),
    .wr_sel  (wr_sel),
    .wr_size (wr_size),
    .sw_en   (sw_en),
    .sw_a    (sw_a),
    .sw_b    (sw_b),
    .bank_q  (state_q.bank)
);

// File: tb/subreg_file_bench.sv
`timescale 1ns/1ps
module subreg_file_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd0_sel = '0, rd1_sel = '0;
    logic [1:0]  rd0_size = '0, rd1_size = '0;
    logic [31:0] rd0_data, rd1_data;
    logic        wr_en = 1'b0, wr_imm = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        wr_err;
    logic        sw_en = 1'b0;
    logic [3:0]  sw_a = '0, sw_b = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    subreg_file u_subreg_file (
        .clk(clk), .rst(rst),
        .rd0_sel(rd0_sel), .rd0_size(rd0_size), .rd0_data(rd0_data),
        .rd1_sel(rd1_sel), .rd1_size(rd1_size), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_imm(wr_imm),
        .wr_data(wr_data), .wr_err(wr_err),
        .sw_en(sw_en), .sw_a(sw_a), .sw_b(sw_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] sel, input logic [1:0] sz,
                      input logic [31:0] exp, input string tag);
        rd0_sel = sel; rd0_size = sz;
        #1;
        check(tag, rd0_data, exp);
    endtask

    task automatic wr(input logic [3:0] sel, input logic [1:0] sz, input logic [31:0] d,
                      input logic imm, input logic exp_err, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_size = sz; wr_data = d; wr_imm = imm;
        #1;
        check(tag, {31'b0, wr_err}, {31'b0, exp_err});
        @(negedge clk);
        wr_en = 1'b0; wr_imm = 1'b0;
    endtask

    task automatic swap(input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        sw_en = 1'b1; sw_a = a; sw_b = b;
        @(negedge clk);
        sw_en = 1'b0;
    endtask

    task automatic t_reset;
        rd(4'd0, 2'd3, 32'h0, "R5 reset A");
        rd(4'd7, 2'd3, 32'h0, "R5 reset DI");
        rd(4'd13, 2'd2, 32'h0, "R5 reset last segment");
    endtask

    task automatic t_views;
        wr(4'd0, 2'd3, 32'h1A2B3C4D, 1'b0, 1'b0, "R2 write A err");
        rd(4'd0, 2'd0, 32'h4D, "R2 low byte");
        rd(4'd0, 2'd1, 32'h3C, "R2 high byte");
        rd(4'd0, 2'd2, 32'h3C4D, "R2 word");
        rd(4'd0, 2'd3, 32'h1A2B3C4D, "R1 R2 dword of A");
    endtask

    task automatic t_merge;
        wr(4'd0, 2'd0, 32'hFFFFFFEE, 1'b0, 1'b0, "R4 lo err");
        rd(4'd0, 2'd3, 32'h1A2B3CEE, "R4 low byte merge");
        wr(4'd0, 2'd1, 32'hAAAAAA55, 1'b0, 1'b0, "R4 hi err");
        rd(4'd0, 2'd3, 32'h1A2B55EE, "R4 high byte merge");
        wr(4'd0, 2'd2, 32'h99991234, 1'b0, 1'b0, "R4 word err");
        rd(4'd0, 2'd3, 32'h1A2B1234, "R4 word merge");
        wr(4'd5, 2'd3, 32'hCAFEF00D, 1'b0, 1'b0, "R4 BP dword err");
        wr(4'd5, 2'd2, 32'h0000BEEF, 1'b0, 1'b0, "R4 BP word err");
        rd(4'd5, 2'd3, 32'hCAFEBEEF, "R4 pointer word merge");
    endtask

    task automatic t_timing;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'd3; wr_size = 2'd3; wr_data = 32'h0BADCAFE;
        rd(4'd3, 2'd3, 32'h0, "R5 not visible before edge");
        @(negedge clk);
        wr_en = 1'b0;
        rd(4'd3, 2'd3, 32'h0BADCAFE, "R5 visible after edge");
    endtask

    task automatic t_illegal;
        wr(4'd6, 2'd0, 32'h000000AA, 1'b0, 1'b1, "R6 byte on SI err");
        rd(4'd6, 2'd3, 32'h0, "R6 SI unchanged");
        wr(4'd8, 2'd3, 32'h12345678, 1'b0, 1'b1, "R6 dword on CS err");
        rd(4'd8, 2'd2, 32'h0, "R6 CS unchanged");
        wr(4'd14, 2'd2, 32'h00001111, 1'b0, 1'b1, "R6 unused select err");
        rd(4'd0, 2'd3, 32'h1A2B1234, "R6 A unchanged");
    endtask

    task automatic t_segment;
        wr(4'd9, 2'd2, 32'h00003000, 1'b0, 1'b0, "R7 DS plain err");
        rd(4'd9, 2'd2, 32'h3000, "R7 DS written");
        wr(4'd9, 2'd2, 32'h00001234, 1'b1, 1'b1, "R7 DS immediate err");
        rd(4'd9, 2'd2, 32'h3000, "R7 DS kept");
        wr(4'd1, 2'd3, 32'h55AA55AA, 1'b1, 1'b0, "R7 B immediate err");
        rd(4'd1, 2'd3, 32'h55AA55AA, "R7 B immediate accepted");
    endtask

    task automatic t_reads;
        wr(4'd4, 2'd3, 32'h12345678, 1'b0, 1'b0, "R3 SP write err");
        rd(4'd4, 2'd0, 32'h0, "R3 SP byte view zero");
        rd(4'd4, 2'd2, 32'h5678, "R3 SP word view");
        rd(4'd9, 2'd3, 32'h0, "R3 DS dword view zero");
        rd(4'd15, 2'd3, 32'h0, "R3 unused select zero");
        rd0_sel = 4'd0; rd0_size = 2'd1;
        rd1_sel = 4'd1; rd1_size = 2'd0;
        #1;
        check("R3 port0 A high", rd0_data, 32'h12);
        check("R3 port1 B low", rd1_data, 32'hAA);
    endtask

    task automatic t_swap;
        swap(4'd0, 4'd5);
        rd(4'd0, 2'd3, 32'hCAFEBEEF, "R8 A after swap");
        rd(4'd5, 2'd3, 32'h1A2B1234, "R8 BP after swap");
        wr(4'd2, 2'd3, 32'h89ABCDEF, 1'b0, 1'b0, "R8 C write err");
        swap(4'd9, 4'd2);
        rd(4'd9, 2'd2, 32'hCDEF, "R8 DS from C");
        rd(4'd2, 2'd3, 32'h00003000, "R8 C from DS");
        swap(4'd0, 4'd14);
        rd(4'd0, 2'd3, 32'hCAFEBEEF, "R8 unused select no swap");
    endtask

    task automatic t_self;
        swap(4'd5, 4'd5);
        rd(4'd5, 2'd3, 32'h1A2B1234, "R9 self swap");
    endtask

    task automatic t_collide;
        @(negedge clk);
        sw_en = 1'b1; sw_a = 4'd0; sw_b = 4'd5;
        wr_en = 1'b1; wr_sel = 4'd0; wr_size = 2'd0; wr_data = 32'h00000077;
        #1;
        check("R10 no err", {31'b0, wr_err}, 32'h0);
        @(negedge clk);
        sw_en = 1'b0; wr_en = 1'b0;
        rd(4'd0, 2'd3, 32'h1A2B1277, "R10 write on swapped A");
        rd(4'd5, 2'd3, 32'hCAFEBEEF, "R10 BP swapped");
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(4'd0, 2'd3, 32'h0, "R5 A cleared");
        rd(4'd9, 2'd2, 32'h0, "R5 DS cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_views();
        t_merge();
        t_timing();
        t_illegal();
        t_segment();
        t_reads();
        t_swap();
        t_self();
        t_collide();
        t_reset_again();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule